// File: doc/BRIEF.md
# Translation Fault Syndrome Encoder

This block sits after an address-translation unit. When a translation attempt finishes, the unit strobes its result into the encoder for one cycle. The result has four parts: a status code, the access kind (load, store or instruction fetch), a special-access class and the effective address. In the next cycle the encoder presents a registered exception kind together with the syndrome values: an error code, a 32-bit data fault status word and a captured data fault address. A one-cycle done pulse marks the update.

Instruction-side faults raise an instruction-storage exception. Data-side faults raise a data-storage exception, with a status word that depends on the fault cause. Loads and stores produce different versions of that word. Direct-store faults on data accesses are steered by access class: some raise a data-storage exception, floating-point accesses raise an alignment exception, and any other class raises a program exception. A successful translation raises nothing and leaves every syndrome register as it was.

Top module: `fault_syndrome_enc`

## Requirements
- R1: After reset, syn_done is 0, syn_exc is 0 (none), and syn_err, syn_status and syn_addr are all zero.
- R2: syn_done is 1 in exactly the cycle after each cycle with rslt_vld high, and 0 otherwise. Back-to-back strobes give back-to-back pulses.
- R3: On a fetch (rslt_kind 2 or 3), status 1 (not found) gives syn_exc 1 (instruction storage) with syn_err 0x40000000. Status 2 (protection) gives syn_exc 1 with syn_err 0x08000000.
- R4: On a fetch, status 3 (no-execute) and status 4 (direct store) both give syn_exc 1 with syn_err 0x10000000.
- R5: A fetch fault leaves syn_status and syn_addr unchanged.
- R6: On a data access (rslt_kind 0 load, 1 store), status 1 gives syn_exc 2 (data storage) with syn_err 0 and syn_status 0x42000000 for a store or 0x40000000 for a load.
- R7: A data access with status 2 gives syn_exc 2, syn_err 0, and syn_status 0x0A000000 for a store or 0x08000000 for a load.
- R8: A data access with status 4 and rslt_class 2 (reservation) gives syn_exc 2 with syn_status 0x06000000 for a store or 0x04000000 for a load. With rslt_class 4 (external control) the words are 0x06100000 and 0x04100000.
- R9: A data access with status 4 and rslt_class 1 (floating point) gives syn_exc 3 (alignment) with syn_err 0x00000001 and leaves syn_status unchanged.
- R10: syn_exc is 4 (program) with syn_err 0x00000020 and syn_status unchanged in three cases: a data access with status 4 and any rslt_class other than 1, 2 or 4; a data access with status 3; and status 5 to 7 on either side.
- R11: Every data-side fault (status not 0, rslt_kind 0 or 1) loads syn_addr with rslt_ea.
- R12: Status 0 (success) sets syn_exc to 0 and leaves syn_err, syn_status and syn_addr unchanged.
- R13: In a cycle without a strobe, syn_exc, syn_err, syn_status and syn_addr hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rslt_vld | input | 1 | One-cycle strobe of a translation result |
| rslt_status | input | 3 | 0 ok, 1 not found, 2 protection, 3 no-execute, 4 direct store, 5-7 reserved |
| rslt_kind | input | 2 | 0 load, 1 store, 2 or 3 fetch |
| rslt_class | input | 3 | 0 integer, 1 floating point, 2 reservation, 3 cache op, 4 external control, 5-7 other |
| rslt_ea | input | ADDR_W | Effective address of the access |
| syn_done | output | 1 | One-cycle pulse after each strobe |
| syn_exc | output | 3 | 0 none, 1 instruction storage, 2 data storage, 3 alignment, 4 program |
| syn_err | output | 32 | Error code |
| syn_status | output | 32 | Data fault status word |
| syn_addr | output | ADDR_W | Captured data fault address |

## Verification
A wrong classification shows at the ports one cycle after the strobe, as the wrong syn_exc or the wrong error or status word. The store-versus-load difference shows as bit 25 of syn_status. A load enable stuck on or off does not always show right away. It may only appear at the next strobe whose cause should have left a register alone, for example a fetch fault that moves syn_addr or a success that changes syn_err. For that reason every such case is followed directly by a check of the held values.

// File: rtl/fse_pkg.sv
package fse_pkg;
  localparam int SYN_W = 32;

  localparam logic [2:0] ST_OK      = 3'd0;
  localparam logic [2:0] ST_NOTFND  = 3'd1;
  localparam logic [2:0] ST_PROT    = 3'd2;
  localparam logic [2:0] ST_NOEXEC  = 3'd3;
  localparam logic [2:0] ST_DSTORE  = 3'd4;

  localparam logic [2:0] CL_FLOAT   = 3'd1;
  localparam logic [2:0] CL_RESV    = 3'd2;
  localparam logic [2:0] CL_EXTCTL  = 3'd4;

  typedef enum logic [2:0] {
    EX_NONE  = 3'd0,
    EX_ISTOR = 3'd1,
    EX_DSTOR = 3'd2,
    EX_ALIGN = 3'd3,
    EX_PROG  = 3'd4
  } exc_e;

  localparam logic [SYN_W-1:0] I_NOTFND   = 32'h4000_0000;
  localparam logic [SYN_W-1:0] I_PROT     = 32'h0800_0000;
  localparam logic [SYN_W-1:0] I_NOEXEC   = 32'h1000_0000;
  localparam logic [SYN_W-1:0] D_NOTFND   = 32'h4000_0000;
  localparam logic [SYN_W-1:0] D_PROT     = 32'h0800_0000;
  localparam logic [SYN_W-1:0] D_RESV     = 32'h0400_0000;
  localparam logic [SYN_W-1:0] D_EXTCTL   = 32'h0410_0000;
  localparam logic [SYN_W-1:0] STORE_FLAG = 32'h0200_0000;
  localparam logic [SYN_W-1:0] ALIGN_FP   = 32'h0000_0001;
  localparam logic [SYN_W-1:0] PROG_INVAL = 32'h0000_0020;

  typedef struct packed {
    exc_e             exc;
    logic [SYN_W-1:0] err;
    logic [SYN_W-1:0] dfsr;
    logic             ld_err;
    logic             ld_dfsr;
    logic             ld_addr;
  } enc_t;

  // Store variant of a data status word sets one extra flag bit.
  function automatic logic [SYN_W-1:0] data_word(logic [SYN_W-1:0] load_word, logic is_store);
    return load_word | (is_store ? STORE_FLAG : '0);
  endfunction

  function automatic enc_t fse_encode(logic [2:0] st, logic [1:0] kind, logic [2:0] cls);
    enc_t o;
    logic store;
    o = '{exc: EX_NONE, err: '0, dfsr: '0, ld_err: 1'b0, ld_dfsr: 1'b0, ld_addr: 1'b0};
    store = (kind == 2'b01);
    if (st != ST_OK) begin
      o.ld_err = 1'b1;
      if (kind[1]) begin
        o.exc = EX_ISTOR;
        case (st)
          ST_NOTFND:            o.err = I_NOTFND;
          ST_PROT:              o.err = I_PROT;
          ST_NOEXEC, ST_DSTORE: o.err = I_NOEXEC;
          default: begin
            o.exc = EX_PROG;
            o.err = PROG_INVAL;
          end
        endcase
      end else begin
        o.ld_addr = 1'b1;
        o.exc     = EX_PROG;
        o.err     = PROG_INVAL;
        if (st == ST_NOTFND || st == ST_PROT) begin
          o.exc     = EX_DSTOR;
          o.err     = '0;
          o.ld_dfsr = 1'b1;
          o.dfsr    = data_word((st == ST_NOTFND) ? D_NOTFND : D_PROT, store);
        end else if (st == ST_DSTORE) begin
          if (cls == CL_RESV || cls == CL_EXTCTL) begin
            o.exc     = EX_DSTOR;
            o.err     = '0;
            o.ld_dfsr = 1'b1;
            o.dfsr    = data_word((cls == CL_RESV) ? D_RESV : D_EXTCTL, store);
          end else if (cls == CL_FLOAT) begin
            o.exc = EX_ALIGN;
            o.err = ALIGN_FP;
          end
        end
      end
    end
    return o;
  endfunction
endpackage

// File: rtl/fse_classify.sv
module fse_classify
  import fse_pkg::*;
(
  input  logic             vld,
  input  logic [2:0]       status,
  input  logic [1:0]       kind,
  input  logic [2:0]       cls,
  output exc_e             exc,
  output logic [SYN_W-1:0] err,
  output logic [SYN_W-1:0] dfsr,
  output logic             ld_err,
  output logic             ld_dfsr,
  output logic             ld_addr
);
  enc_t enc;

  always_comb begin
    enc     = fse_encode(status, kind, cls);
    exc     = enc.exc;
    err     = enc.err;
    dfsr    = enc.dfsr;
    ld_err  = vld & enc.ld_err;
    ld_dfsr = vld & enc.ld_dfsr;
    ld_addr = vld & enc.ld_addr;
  end
endmodule

// File: rtl/fse_syndrome_regs.sv
module fse_syndrome_regs
  import fse_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld,
  input  exc_e              exc_in,
  input  logic [SYN_W-1:0]  err_in,
  input  logic [SYN_W-1:0]  dfsr_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              ld_err,
  input  logic              ld_dfsr,
  input  logic              ld_addr,
  output logic              done,
  output exc_e              exc_q,
  output logic [SYN_W-1:0]  err_q,
  output logic [SYN_W-1:0]  dfsr_q,
  output logic [ADDR_W-1:0] addr_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done   <= 1'b0;
      exc_q  <= EX_NONE;
      err_q  <= '0;
      dfsr_q <= '0;
      addr_q <= '0;
    end else begin
      done <= vld;
      if (vld)     exc_q  <= exc_in;
      if (ld_err)  err_q  <= err_in;
      if (ld_dfsr) dfsr_q <= dfsr_in;
      if (ld_addr) addr_q <= addr_in;
    end
  end
endmodule

// File: rtl/fault_syndrome_enc.sv
module fault_syndrome_enc
  import fse_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rslt_vld,
  input  logic [2:0]        rslt_status,
  input  logic [1:0]        rslt_kind,
  input  logic [2:0]        rslt_class,
  input  logic [ADDR_W-1:0] rslt_ea,
  output logic              syn_done,
  output logic [2:0]        syn_exc,
  output logic [31:0]       syn_err,
  output logic [31:0]       syn_status,
  output logic [ADDR_W-1:0] syn_addr
);
  exc_e             enc_exc;
  exc_e             exc_q;
  logic [SYN_W-1:0] enc_err;
  logic [SYN_W-1:0] enc_dfsr;
  logic             ld_err;
  logic             ld_dfsr;
  logic             ld_addr;

  fse_classify u_cls (
    .vld     (rslt_vld),
    .status  (rslt_status),
    .kind    (rslt_kind),
    .cls     (rslt_class),
    .exc     (enc_exc),
    .err     (enc_err),
    .dfsr    (enc_dfsr),
    .ld_err  (ld_err),
    .ld_dfsr (ld_dfsr),
    .ld_addr (ld_addr)
  );

  fse_syndrome_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .vld     (rslt_vld),
    .exc_in  (enc_exc),
    .err_in  (enc_err),
    .dfsr_in (enc_dfsr),
    .addr_in (rslt_ea),
    .ld_err  (ld_err),
    .ld_dfsr (ld_dfsr),
    .ld_addr (ld_addr),
    .done    (syn_done),
    .exc_q   (exc_q),
    .err_q   (syn_err),
    .dfsr_q  (syn_status),
    .addr_q  (syn_addr)
  );

  assign syn_exc = exc_q;
endmodule

// File: rtl/fse_checker.sv
module fse_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rslt_vld,
  input logic [2:0]        rslt_status,
  input logic [1:0]        rslt_kind,
  input logic [ADDR_W-1:0] rslt_ea,
  input logic              syn_done,
  input logic [2:0]        syn_exc,
  input logic [31:0]       syn_err,
  input logic [31:0]       syn_status,
  input logic [ADDR_W-1:0] syn_addr,
  input logic              ld_addr
);
  a_r2_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rslt_vld |=> syn_done);
  a_r2_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rslt_vld |=> !syn_done);
  a_r12_ok_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (rslt_vld && rslt_status == 3'd0) |=>
      (syn_exc == 3'd0 && $stable(syn_err) && $stable(syn_status) && $stable(syn_addr)));
  a_r5_fetch_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (rslt_vld && rslt_kind[1]) |=> ($stable(syn_status) && $stable(syn_addr)));
  a_r11_addr_capture: assert property (@(posedge clk) disable iff (!rst_n)
    ld_addr |=> (syn_addr == $past(rslt_ea)));
  a_r11_data_fault_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (rslt_vld && rslt_status != 3'd0 && !rslt_kind[1]) |-> ld_addr);
  a_r13_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rslt_vld |=> ($stable(syn_exc) && $stable(syn_err) && $stable(syn_status) && $stable(syn_addr)));
  a_r6_dsi_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (syn_done && syn_exc == 3'd2) |-> syn_err == 32'd0);
endmodule

bind fault_syndrome_enc fse_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rslt_vld    (rslt_vld),
  .rslt_status (rslt_status),
  .rslt_kind   (rslt_kind),
  .rslt_ea     (rslt_ea),
  .syn_done    (syn_done),
  .syn_exc     (syn_exc),
  .syn_err     (syn_err),
  .syn_status  (syn_status),
  .syn_addr    (syn_addr),
  .ld_addr     (ld_addr)
);

// File: tb/fault_syndrome_enc_test.sv
`timescale 1ns/1ps
module fault_syndrome_enc_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rslt_vld = 1'b0;
  logic [2:0]  rslt_status = '0;
  logic [1:0]  rslt_kind = '0;
  logic [2:0]  rslt_class = '0;
  logic [31:0] rslt_ea = '0;
  logic        syn_done;
  logic [2:0]  syn_exc;
  logic [31:0] syn_err, syn_status, syn_addr;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [2:0]  m_exc;
  logic [31:0] m_err, m_stat, m_addr;

  always #2.5 clk = ~clk;

  fault_syndrome_enc uut (
    .clk(clk), .rst_n(rst_n), .rslt_vld(rslt_vld), .rslt_status(rslt_status),
    .rslt_kind(rslt_kind), .rslt_class(rslt_class), .rslt_ea(rslt_ea),
    .syn_done(syn_done), .syn_exc(syn_exc), .syn_err(syn_err),
    .syn_status(syn_status), .syn_addr(syn_addr)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Reference model written from the requirement tables.
  task automatic model(input logic [2:0] st, input logic [1:0] k, input logic [2:0] c, input logic [31:0] ea);
    logic st_bit;
    st_bit = (k == 2'd1);
    if (st == 3'd0) begin
      m_exc = 3'd0;
    end else if (k >= 2'd2) begin
      m_exc = 3'd1;
      if (st == 3'd1)      m_err = 32'h4000_0000;
      else if (st == 3'd2) m_err = 32'h0800_0000;
      else if (st <= 3'd4) m_err = 32'h1000_0000;
      else begin m_exc = 3'd4; m_err = 32'h20; end
    end else begin
      m_addr = ea;
      if (st == 3'd1) begin
        m_exc = 3'd2; m_err = 0; m_stat = st_bit ? 32'h4200_0000 : 32'h4000_0000;
      end else if (st == 3'd2) begin
        m_exc = 3'd2; m_err = 0; m_stat = st_bit ? 32'h0A00_0000 : 32'h0800_0000;
      end else if (st == 3'd4 && c == 3'd2) begin
        m_exc = 3'd2; m_err = 0; m_stat = st_bit ? 32'h0600_0000 : 32'h0400_0000;
      end else if (st == 3'd4 && c == 3'd4) begin
        m_exc = 3'd2; m_err = 0; m_stat = st_bit ? 32'h0610_0000 : 32'h0410_0000;
      end else if (st == 3'd4 && c == 3'd1) begin
        m_exc = 3'd3; m_err = 32'h1;
      end else begin
        m_exc = 3'd4; m_err = 32'h20;
      end
    end
  endtask

  task automatic cmp_all(input string tag);
    chk(tag, "exc", {29'd0, syn_exc}, {29'd0, m_exc});
    chk(tag, "err", syn_err, m_err);
    chk(tag, "status", syn_status, m_stat);
    chk(tag, "addr", syn_addr, m_addr);
  endtask

  task automatic apply(input string tag, input logic [2:0] st, input logic [1:0] k, input logic [2:0] c, input logic [31:0] ea);
    @(negedge clk);
    rslt_vld = 1'b1; rslt_status = st; rslt_kind = k; rslt_class = c; rslt_ea = ea;
    model(st, k, c, ea);
    @(negedge clk);
    rslt_vld = 1'b0;
    chk({tag, " R2 done"}, "done", {31'd0, syn_done}, 32'd1);
    cmp_all(tag);
    @(negedge clk);
    chk({tag, " R2 pulse end"}, "done", {31'd0, syn_done}, 32'd0);
    cmp_all({tag, " R13 hold"});
  endtask

  task automatic t_reset;
    m_exc = 0; m_err = 0; m_stat = 0; m_addr = 0;
    chk("R1 reset", "done", {31'd0, syn_done}, 32'd0);
    cmp_all("R1 reset");
  endtask

  task automatic t_fetch;
    apply("R6 seed", 3'd1, 2'd1, 3'd0, 32'hA5A5_0000);
    apply("R3 fetch notfound", 3'd1, 2'd2, 3'd0, 32'h1111_1000);
    apply("R3 fetch prot kind3", 3'd2, 2'd3, 3'd0, 32'h2222_2000);
    apply("R4 fetch noexec", 3'd3, 2'd2, 3'd0, 32'h3333_3000);
    apply("R4 R5 fetch dstore", 3'd4, 2'd2, 3'd2, 32'h4444_4000);
    apply("R10 fetch reserved", 3'd6, 2'd2, 3'd0, 32'h5555_5000);
  endtask

  task automatic t_data;
    apply("R6 load notfound", 3'd1, 2'd0, 3'd0, 32'h0000_1004);
    apply("R6 R11 store notfound", 3'd1, 2'd1, 3'd0, 32'h0000_2008);
    apply("R7 load prot", 3'd2, 2'd0, 3'd3, 32'h0000_300C);
    apply("R7 store prot", 3'd2, 2'd1, 3'd3, 32'h0000_4010);
  endtask

  task automatic t_dstore;
    apply("R8 resv load", 3'd4, 2'd0, 3'd2, 32'h8000_0010);
    apply("R8 resv store", 3'd4, 2'd1, 3'd2, 32'h8000_0020);
    apply("R8 ext load", 3'd4, 2'd0, 3'd4, 32'h8000_0030);
    apply("R8 ext store", 3'd4, 2'd1, 3'd4, 32'h8000_0040);
    apply("R9 R11 float store", 3'd4, 2'd1, 3'd1, 32'h8000_0050);
  endtask

  task automatic t_program;
    apply("R10 dstore int", 3'd4, 2'd0, 3'd0, 32'h9000_0000);
    apply("R10 dstore cache", 3'd4, 2'd1, 3'd3, 32'h9000_0100);
    apply("R10 dstore other", 3'd4, 2'd0, 3'd7, 32'h9000_0200);
    apply("R10 data noexec", 3'd3, 2'd1, 3'd0, 32'h9000_0300);
    apply("R10 data reserved", 3'd5, 2'd0, 3'd0, 32'h9000_0400);
  endtask

  task automatic t_success;
    apply("R12 ok load", 3'd0, 2'd0, 3'd2, 32'hDEAD_0000);
    apply("R12 ok fetch", 3'd0, 2'd2, 3'd0, 32'hBEEF_0000);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    rslt_vld = 1'b1; rslt_status = 3'd2; rslt_kind = 2'd0; rslt_class = 3'd0; rslt_ea = 32'h0C0C_0000;
    model(3'd2, 2'd0, 3'd0, 32'h0C0C_0000);
    @(negedge clk);
    chk("R2 b2b first", "done", {31'd0, syn_done}, 32'd1);
    cmp_all("R7 b2b first");
    rslt_status = 3'd1; rslt_kind = 2'd3; rslt_ea = 32'h0D0D_0000;
    model(3'd1, 2'd3, 3'd0, 32'h0D0D_0000);
    @(negedge clk);
    rslt_vld = 1'b0;
    chk("R2 b2b second", "done", {31'd0, syn_done}, 32'd1);
    cmp_all("R3 R5 b2b second");
    @(negedge clk);
    chk("R2 b2b end", "done", {31'd0, syn_done}, 32'd0);
  endtask

  task automatic t_idle;
    rslt_status = 3'd1; rslt_kind = 2'd1; rslt_ea = 32'hFFFF_FFFF;
    repeat (4) @(negedge clk);
    chk("R13 idle", "done", {31'd0, syn_done}, 32'd0);
    cmp_all("R13 idle inputs moving");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_fetch();
    t_data();
    t_dstore();
    t_program();
    t_success();
    t_back_to_back();
    t_idle();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule